// File: doc/BRIEF.md
# Dual-Clock Watchdog and Interval Timer

This block supervises software with a 16-bit up-counter. The counter advances on one of two clock-enable strobes: a fast one from the sub-main clock and a slow one from the auxiliary clock. Its timeout is one of four counter taps, so each strobe offers four periods and the block has eight timeout choices in all. It runs from reset in watchdog mode. If software does not clear the counter before the selected tap is crossed, the block raises a one-cycle system reset request.

A mode bit turns the block into an interval timer. In that mode each tap crossing sets a sticky interrupt flag instead of requesting a reset, and the counter keeps running. Software changes the block only through a 16-bit control write. The upper byte of the write is a key. A write with a wrong key is treated as a software fault and raises a reset request, whatever the mode. A control write can also clear the counter to kick the watchdog, and it can hold the counter frozen.

All pins are plain control and status signals. There is no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control byte reads 0x00, `rst_req` and `irq_flag` are low, and the counter starts at zero and runs in watchdog mode from the fast strobe with the longest period.
- R2: In watchdog mode with no kick, `rst_req` is high in the clock cycle of the tick that completes the selected period, counted from the clear or from reset. From reset with the fast strobe high every cycle, this is tick 32768.
- R3: Control bits [1:0] select the period: 0 gives 32768 ticks, 1 gives 8192, 2 gives 512 and 3 gives 64. The period is measured from the edge that accepts a clearing write.
- R4: Control bit 2 selects the strobe: 0 is `tick_fast` and 1 is `tick_slow`. The strobe that is not selected has no effect on the count.
- R5: A write whose upper byte is not 0x5A leaves the control byte unchanged. It sets `rst_req` on the edge that takes the write, in watchdog mode and in interval mode alike.
- R6: A keyed write with bit 3 set zeroes the counter on the edge that takes the write, so no timeout follows for a full period. Bit 3 always reads back as 0, and bits 6:5 read back as 0.
- R7: Control bit 7 freezes the counter without clearing it. After the bit is released, counting resumes from the frozen value.
- R8: With control bit 4 set (interval mode), each tap crossing sets `irq_flag` and raises no `rst_req`. The flag stays set until `irq_clr` is high at a clock edge, and the counter keeps running so that later crossings set the flag again.
- R9: A timeout reset request lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Count strobe derived from the sub-main clock |
| tick_slow | input | 1 | Count strobe derived from the auxiliary clock |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Write value: key in [15:8], control in [7:0] |
| ctl_rdata | output | 8 | Current control byte |
| irq_clr | input | 1 | Clears the interval flag |
| rst_req | output | 1 | System reset request pulse |
| irq_flag | output | 1 | Sticky interval interrupt flag |

## Verification
The timeout is driven four ways: uninterrupted counting from reset, a kick after each of two tap selections, repeated kicks that land inside the period, and a freeze in the middle of a period. These cases tell a wrong tap, a clear that does not take effect, and a hold that also clears apart by the exact cycle of the request. The slow strobe is pulsed sparsely while the fast strobe stays high, so counting on the wrong strobe shows up as a request that comes early. In interval mode, a crossing, a wrong key and a flag clear between two crossings separate the interrupt path from the reset path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;
  localparam int NTAP  = 4;
  localparam int SEL_W = $clog2(NTAP);
  localparam logic [7:0] WDT_KEY = 8'h5A;
  // counter bits that must all be one for a crossing; index = select code
  localparam int TAP_LEN [NTAP] = '{15, 13, 9, 6};

  typedef struct packed {
    logic             hold;
    logic [1:0]       rsvd;
    logic             intv;
    logic             clr;
    logic             src;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output ctl_t        ctl,
  output logic        clr_pulse,
  output logic        key_fail
);
  logic key_ok;
  ctl_t nxt;

  assign key_ok    = (wdata[15:8] == WDT_KEY);
  assign key_fail  = we && !key_ok;
  assign clr_pulse = we && key_ok && wdata[3];

  always_comb begin
    nxt      = ctl_t'(wdata[7:0]);
    nxt.clr  = 1'b0;
    nxt.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ctl <= '0;
    else if (we && key_ok)  ctl <= nxt;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             src,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             timeout
);
  logic            adv;
  logic [NTAP-1:0] tap_full;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap_full[i] = &cnt[TAP_LEN[i]-1:0];
  end

  assign adv     = (src ? tick_b : tick_a) && !hold;
  assign timeout = adv && tap_full[sel] && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic key_fail,
  input  logic intv,
  input  logic irq_clr,
  output logic rst_req,
  output logic irq_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      rst_req  <= key_fail || (timeout && !intv);
      irq_flag <= (timeout && intv) || (irq_flag && !irq_clr);
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        ctl_we,
  input  logic [15:0] ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic        irq_clr,
  output logic        rst_req,
  output logic        irq_flag
);
  ctl_t             ctl;
  logic             clr_pulse;
  logic             key_fail;
  logic             timeout;
  logic [CNT_W-1:0] count_q;

  wdt_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .clr_pulse(clr_pulse), .key_fail(key_fail)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_fast), .tick_b(tick_slow),
    .src(ctl.src), .sel(ctl.sel), .hold(ctl.hold), .clr(clr_pulse),
    .cnt(count_q), .timeout(timeout)
  );

  wdt_event u_evt (
    .clk(clk), .rst_n(rst_n), .timeout(timeout), .key_fail(key_fail),
    .intv(ctl.intv), .irq_clr(irq_clr), .rst_req(rst_req), .irq_flag(irq_flag)
  );

  assign ctl_rdata = ctl;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [15:0] ctl_wdata,
  input logic [7:0]  ctl_rdata,
  input logic        irq_clr,
  input logic        rst_req,
  input logic        irq_flag,
  input logic [15:0] count_q
);
  p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[15:8] != 8'h5A |=> rst_req && $stable(ctl_rdata));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[15:8] == 8'h5A && ctl_wdata[3] |=> count_q == 16'd0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7] && !ctl_we |=> $stable(count_q));

  p_no_reset_interval_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] && !ctl_we |=> !rst_req);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !ctl_we |=> !rst_req);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .irq_clr(irq_clr), .rst_req(rst_req),
  .irq_flag(irq_flag), .count_q(count_q)
);

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b1;
  logic        tick_slow = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        irq_clr = 1'b0;
  logic        rst_req;
  logic        irq_flag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pulses = 0;
  int       exp_cyc [$];
  string    exp_req [$];

  always #5 clk = ~clk;

  wdt_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq_clr(irq_clr), .rst_req(rst_req), .irq_flag(irq_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every reset request must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      pulses++;
      if (exp_cyc.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected rst_req actual=%0d expected=none", cyc);
      end else begin
        check(exp_req.pop_front(), cyc, exp_cyc.pop_front());
      end
    end
  end

  task automatic push(input int c, input string req);
    exp_cyc.push_back(c);
    exp_req.push_back(req);
  endtask

  // driver: called at a falling edge; returns the cycle number of the accepting edge
  task automatic wr(input logic [7:0] key, input logic [7:0] v,
                    input bit expect_rst, input string req, output int c);
    ctl_we = 1'b1;
    ctl_wdata = {key, v};
    @(posedge clk); #1;
    c = cyc;
    if (expect_rst) push(c, req);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic drain;
    while (exp_cyc.size() != 0) @(negedge clk);
  endtask

  initial begin
    int cw, cw2, cw3, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(32768, "R2");
    @(negedge clk);
    check("R1 ctl", ctl_rdata, 8'h00);
    check("R1 rst_req", rst_req, 0);
    check("R1 irq", irq_flag, 0);
    drain();

    // R3: shortest and two middle periods, each measured from a clearing write
    wr(8'h5A, 8'h0B, 0, "", cw); push(cw + 64, "R3 64");
    drain();
    wr(8'h5A, 8'h0A, 0, "", cw); push(cw + 512, "R3 512");
    drain();
    wr(8'h5A, 8'h09, 0, "", cw); push(cw + 8192, "R3 8192");
    drain();

    // R6: repeated kicks inside the 64-tick period prevent any request
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      wr(8'h5A, 8'h0B, 0, "", cw);
      repeat (40) @(negedge clk);
    end
    check("R6 kicks", pulses, p0);
    check("R6 clr reads 0", ctl_rdata, 8'h03);

    // R7: freeze mid-period, release, resume from frozen value
    wr(8'h5A, 8'h0B, 0, "", cw);
    repeat (30) @(negedge clk);
    wr(8'h5A, 8'h83, 0, "", cw2);
    check("R7 hold bit", ctl_rdata, 8'h83);
    repeat (200) @(negedge clk);
    wr(8'h5A, 8'h03, 0, "", cw3);
    push(cw3 + 64 - (cw2 - cw), "R7 resume");
    drain();

    // R5: wrong key in watchdog mode
    wr(8'h5A, 8'h08, 0, "", cw);
    wr(8'h12, 8'h9F, 1, "R5 bad key", cw);
    drain();
    check("R5 ctl kept", ctl_rdata, 8'h00);

    // R4: slow strobe selected while the fast one stays high
    wr(8'h5A, 8'h0F, 0, "", cw);
    for (int i = 0; i < 63; i++) begin
      tick_slow = 1'b1; @(negedge clk);
      tick_slow = 1'b0; @(negedge clk);
    end
    check("R4 fast ignored", exp_cyc.size() + pulses, pulses);
    tick_slow = 1'b1;
    @(posedge clk); #1;
    push(cyc, "R4 slow tick");
    @(negedge clk);
    tick_slow = 1'b0;
    drain();

    // R8: interval mode
    wr(8'h5A, 8'h1B, 0, "", cw);
    p0 = pulses;
    while (cyc < cw + 63) @(negedge clk);
    check("R8 irq before", irq_flag, 0);
    @(negedge clk);
    check("R8 irq set", irq_flag, 1);
    wr(8'h33, 8'h00, 1, "R5 bad key interval", cw2);
    drain();
    check("R8 no timeout reset", pulses, p0 + 1);
    check("R8 irq sticky", irq_flag, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R8 irq cleared", irq_flag, 0);
    while (cyc < cw + 128) @(negedge clk);
    check("R8 irq again", irq_flag, 1);
    check("R8 ctl", ctl_rdata, 8'h13);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule